// File: doc/BRIEF.md
# Event-Driven PWM Waveform Generator

This block is a single pulse-width-modulation channel. A counter, paced by a clock divider, runs upward, downward or alternately up and down between zero and a programmable top value. Four counter events shape the waveform: reaching zero, reaching the top value, and matching a compare value, which counts as two separate events depending on whether the counter is rising or falling. Each event carries its own two-bit action that leaves the waveform level alone, forces it low, forces it high or flips it. This lets edge-aligned, centre-aligned and one-off waveforms all come from the same datapath.

Software-written top and compare values are held in shadow registers. They take effect only where a counting cycle restarts, so a period is never cut short or stretched part-way through. The final pin value can be overridden with a fixed level and can be inverted. The four event strobes are also brought out so that a neighbouring trigger or dead-time stage can follow the counter. The clock divider is meant to be shared with a sibling channel: both channels see the same divide setting.

Top module: `evpwm_channel`

## Requirements
- R1: While reset is held and right after it, `cnt_value` is 0, all four event strobes are 0, and `pwm_out` is 0 when `cfg_invert` and `mask_en` are 0.
- R2: With divide setting N on `cfg_psc` (1 to 4095), the counter steps once every N clock cycles. A setting of 0 behaves as 1.
- R3: `cfg_mode` selects the counting pattern. In mode 0 the counter goes 0 up to P and then back to 0. In mode 1 it goes P down to 0 and then back to P. In mode 2 it rises from 0 to P, then falls back to 0, and repeats. Mode 3 behaves as mode 0.
- R4: An event strobe is high for exactly the one clock cycle in which the counter steps away from its matching value. The zero strobe matches 0 and the period strobe matches P. The compare-up strobe matches the compare value while the counter is rising, which includes the top of mode 2. The compare-down strobe matches the compare value while it is falling, which includes the bottom of mode 2. In mode 2 the zero and period strobes fire once per turnaround.
- R5: Action codes are 0 no change, 1 force low, 2 force high and 3 toggle. The internal level takes the new value on the clock edge that ends the strobe cycle.
- R6: When several strobes are high together, only the action of the highest-ranked one is applied: period first, then compare, then zero. This holds even when that action is code 0.
- R7: `cfg_period` and `cfg_compare` are taken into use only at the restart point of a counting cycle. In mode 0 that is when the counter leaves P, in mode 1 when it leaves 0, and in mode 2 when it leaves 0 on the way down. They are also taken in on a clear and on every step while the counter is stopped.
- R8: An active top value of 0 stops the counter at 0 and suppresses all strobes. Once a non-zero value is taken in, the counter jumps to its start value: P in mode 1, otherwise 0.
- R9: When `mask_en` is 1, the level driven toward the pin is `mask_level` in place of the waveform level.
- R10: When `cfg_invert` is 1, `pwm_out` is the complement of the masked or unmasked level.
- R11: A cycle with `cnt_clear` high suppresses all strobes. On the next edge it restarts the divider, takes in the shadow values and puts the counter at its start value (P in mode 1, otherwise 0, rising). The waveform level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_psc | input | PSC_W | Clock divide setting |
| cfg_mode | input | 2 | Counting pattern: 0 up, 1 down, 2 up-down |
| cfg_period | input | CNT_W | Top value P, shadowed |
| cfg_compare | input | CNT_W | Compare value, shadowed |
| act_zero | input | 2 | Action on the zero event |
| act_cmp_up | input | 2 | Action on compare while rising |
| act_period | input | 2 | Action on the period event |
| act_cmp_dn | input | 2 | Action on compare while falling |
| cfg_invert | input | 1 | Invert the final output |
| mask_en | input | 1 | Replace the waveform with mask_level |
| mask_level | input | 1 | Forced level while masked |
| cnt_clear | input | 1 | Restart the counter at its start value |
| pwm_out | output | 1 | Channel output |
| ev_zero | output | 1 | Zero event strobe |
| ev_cmp_up | output | 1 | Compare event strobe, rising |
| ev_period | output | 1 | Period event strobe |
| ev_cmp_dn | output | 1 | Compare event strobe, falling |
| cnt_value | output | CNT_W | Current counter value |

## Verification
The bench sweeps every mode against small top values, compare values from 0 up to one past the top, and every action code. The cases it aims at are a compare equal to zero or to the top, where a wrong priority order would apply the weaker action, and the up-down turnarounds, where a design that misses the direction at the extremes would fire zero or period twice or send compare to the wrong strobe. It rewrites the top and compare values in the middle of a cycle, so that a design loading them early shows a shortened period. It also writes a top value of 0, where a design that keeps counting or keeps strobing is caught. Divide settings of 0 and 4 expose an off-by-one in the divider, and clears in every mode expose a wrong start value in down mode.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;

   typedef enum logic [1:0] {
      CNT_UP   = 2'd0,
      CNT_DOWN = 2'd1,
      CNT_UPDN = 2'd2,
      CNT_RSVD = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } wave_act_e;

   typedef struct packed {
      logic zero;
      logic cmp_up;
      logic period;
      logic cmp_dn;
   } evt_t;

   function automatic logic apply_act(input wave_act_e a, input logic cur);
      case (a)
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/evpwm_prescaler.sv
module evpwm_prescaler #(
   parameter int PSC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PSC_W-1:0] div,
   input  logic             restart,
   output logic             tick
);
   localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

   logic [PSC_W-1:0] pcnt_q;
   logic [PSC_W-1:0] last;
   logic             reach;

   // divide setting 0 is treated as 1
   assign last  = (div == '0) ? '0 : div - ONE;
   assign reach = (pcnt_q >= last);
   assign tick  = reach & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt_q <= '0;
      else if (restart || reach) pcnt_q <= '0;
      else                       pcnt_q <= pcnt_q + ONE;
   end
endmodule

// File: rtl/evpwm_counter.sv
module evpwm_counter
   import evpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_compare,
   output logic [CNT_W-1:0] cnt,
   output evt_t             evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] per_q, per_d;
   logic [CNT_W-1:0] cmp_q, cmp_d;
   logic             dir_q, dir_d;
   logic             is_down, is_updn, stopped;
   logic             at_zero, at_per, at_cmp, rising, live, boundary;

   assign is_down = (mode == CNT_DOWN);
   assign is_updn = (mode == CNT_UPDN);
   assign stopped = (per_q == '0);
   assign at_zero = (cnt_q == '0);
   assign at_per  = (cnt_q == per_q);
   assign at_cmp  = (cnt_q == cmp_q);
   assign rising  = !is_down && (!is_updn || dir_q);
   assign live    = tick && !stopped;

   assign evt.zero   = live && at_zero;
   assign evt.period = live && at_per;
   assign evt.cmp_up = live && at_cmp && rising;
   assign evt.cmp_dn = live && at_cmp && !rising;

   // restart point of a counting cycle: shadow values are taken in here
   always_comb begin
      if (stopped)      boundary = 1'b1;
      else if (is_down) boundary = at_zero;
      else if (is_updn) boundary = at_zero && !dir_q;
      else              boundary = at_per;
   end

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      per_d = per_q;
      cmp_d = cmp_q;
      if (clear) begin
         per_d = cfg_period;
         cmp_d = cfg_compare;
         cnt_d = is_down ? cfg_period : '0;
         dir_d = !is_down;
      end else if (tick) begin
         if (boundary) begin
            per_d = cfg_period;
            cmp_d = cfg_compare;
            dir_d = !is_down;
            if (cfg_period == '0)          cnt_d = '0;
            else if (is_down)              cnt_d = cfg_period;
            else if (is_updn && !stopped)  cnt_d = ONE;
            else                           cnt_d = '0;
         end else if (is_down) begin
            cnt_d = cnt_q - ONE;
         end else if (is_updn) begin
            if (dir_q && at_per) begin
               cnt_d = cnt_q - ONE;
               dir_d = 1'b0;
            end else if (dir_q) begin
               cnt_d = cnt_q + ONE;
            end else begin
               cnt_d = cnt_q - ONE;
            end
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         cmp_q <= '0;
         dir_q <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         per_q <= per_d;
         cmp_q <= cmp_d;
         dir_q <= dir_d;
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/evpwm_wavegen.sv
module evpwm_wavegen
   import evpwm_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  evt_t      evt,
   input  wave_act_e act_zero,
   input  wave_act_e act_cmp_up,
   input  wave_act_e act_period,
   input  wave_act_e act_cmp_dn,
   input  logic      mask_en,
   input  logic      mask_level,
   input  logic      invert,
   output logic      lvl,
   output logic      pwm
);
   wave_act_e sel;
   logic      fired;
   logic      lvl_q;
   logic      shaped;

   // ranking: period, then compare (either direction), then zero
   always_comb begin
      fired = 1'b1;
      if (evt.period)      sel = act_period;
      else if (evt.cmp_up) sel = act_cmp_up;
      else if (evt.cmp_dn) sel = act_cmp_dn;
      else if (evt.zero)   sel = act_zero;
      else begin
         sel   = ACT_NONE;
         fired = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lvl_q <= 1'b0;
      else if (fired) lvl_q <= apply_act(sel, lvl_q);
   end

   assign lvl    = lvl_q;
   assign shaped = (mask_en ? mask_level : lvl_q) ^ invert;

   if (OUT_REG) begin : g_out_flop
      logic pwm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= shaped;
      end
      assign pwm = pwm_q;
   end else begin : g_out_comb
      assign pwm = shaped;
   end
endmodule

// File: rtl/evpwm_channel.sv
module evpwm_channel
   import evpwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PSC_W-1:0] cfg_psc,
   input  logic [1:0]       cfg_mode,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_compare,
   input  logic [1:0]       act_zero,
   input  logic [1:0]       act_cmp_up,
   input  logic [1:0]       act_period,
   input  logic [1:0]       act_cmp_dn,
   input  logic             cfg_invert,
   input  logic             mask_en,
   input  logic             mask_level,
   input  logic             cnt_clear,
   output logic             pwm_out,
   output logic             ev_zero,
   output logic             ev_cmp_up,
   output logic             ev_period,
   output logic             ev_cmp_dn,
   output logic [CNT_W-1:0] cnt_value
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("evpwm_channel: CNT_W must lie in 2..32");
   end
   if (PSC_W < 1 || PSC_W > 24) begin : g_bad_psc_w
      $error("evpwm_channel: PSC_W must lie in 1..24");
   end

   logic tick;
   evt_t evt;
   logic wave_lvl;

   evpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (cfg_psc),
      .restart (cnt_clear),
      .tick    (tick)
   );

   evpwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .clear       (cnt_clear),
      .mode        (cnt_mode_e'(cfg_mode)),
      .cfg_period  (cfg_period),
      .cfg_compare (cfg_compare),
      .cnt         (cnt_value),
      .evt         (evt)
   );

   evpwm_wavegen #(.OUT_REG(OUT_REG)) u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .act_zero   (wave_act_e'(act_zero)),
      .act_cmp_up (wave_act_e'(act_cmp_up)),
      .act_period (wave_act_e'(act_period)),
      .act_cmp_dn (wave_act_e'(act_cmp_dn)),
      .mask_en    (mask_en),
      .mask_level (mask_level),
      .invert     (cfg_invert),
      .lvl        (wave_lvl),
      .pwm        (pwm_out)
   );

   assign ev_zero   = evt.zero;
   assign ev_cmp_up = evt.cmp_up;
   assign ev_period = evt.period;
   assign ev_cmp_dn = evt.cmp_dn;
endmodule

// File: rtl/evpwm_channel_chk.sv
module evpwm_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_mode,
   input logic             cnt_clear,
   input logic [CNT_W-1:0] cnt_value,
   input logic             ev_zero,
   input logic             ev_cmp_up,
   input logic             ev_period,
   input logic             ev_cmp_dn,
   input logic [1:0]       act_period,
   input logic [1:0]       act_cmp_dn,
   input logic             lvl
);
   // R4: compare strobe belongs to exactly one direction
   a_r4_cmp_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_cmp_up && ev_cmp_dn));

   // R3: counting up wraps from the top to zero
   a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_period && cfg_mode == 2'd0) |=> (cnt_value == '0));

   // R3: the top value is never strobed on two consecutive cycles
   a_r3_no_double_period: assert property (@(posedge clk) disable iff (!rst_n)
      ev_period |=> !ev_period);

   // R11: clear puts a non-down counter at zero
   a_r11_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clear && cfg_mode != 2'd1) |=> (cnt_value == '0));

   // R5: force-high on the period event
   a_r5_period_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_period && act_period == 2'd2) |=> lvl);

   // R6: compare outranks zero at the bottom of a falling count
   a_r6_cmp_over_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_cmp_dn && ev_zero && act_cmp_dn == 2'd2) |=> lvl);
endmodule

bind evpwm_channel evpwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_mode   (cfg_mode),
   .cnt_clear  (cnt_clear),
   .cnt_value  (cnt_value),
   .ev_zero    (ev_zero),
   .ev_cmp_up  (ev_cmp_up),
   .ev_period  (ev_period),
   .ev_cmp_dn  (ev_cmp_dn),
   .act_period (act_period),
   .act_cmp_dn (act_cmp_dn),
   .lvl        (wave_lvl)
);

// File: tb/evpwm_channel_bench.sv
module evpwm_channel_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [11:0] cfg_psc = '0;
   logic [1:0]  cfg_mode = '0;
   logic [15:0] cfg_period = '0;
   logic [15:0] cfg_compare = '0;
   logic [1:0]  act_zero = '0, act_cmp_up = '0, act_period = '0, act_cmp_dn = '0;
   logic        cfg_invert = 1'b0, mask_en = 1'b0, mask_level = 1'b0, cnt_clear = 1'b0;
   logic        pwm_out, ev_zero, ev_cmp_up, ev_period, ev_cmp_dn;
   logic [15:0] cnt_value;

   evpwm_channel u_evpwm_channel (
      .clk(clk), .rst_n(rst_n), .cfg_psc(cfg_psc), .cfg_mode(cfg_mode),
      .cfg_period(cfg_period), .cfg_compare(cfg_compare),
      .act_zero(act_zero), .act_cmp_up(act_cmp_up), .act_period(act_period),
      .act_cmp_dn(act_cmp_dn), .cfg_invert(cfg_invert), .mask_en(mask_en),
      .mask_level(mask_level), .cnt_clear(cnt_clear), .pwm_out(pwm_out),
      .ev_zero(ev_zero), .ev_cmp_up(ev_cmp_up), .ev_period(ev_period),
      .ev_cmp_dn(ev_cmp_dn), .cnt_value(cnt_value)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // arithmetic reference from the requirements
   int m_cnt, m_per, m_cmp, m_pc, m_div;
   bit m_dir, m_lvl, m_tick, m_live, m_rise, m_bnd;
   bit x_z, x_cu, x_p, x_cd;

   function automatic bit act_of(logic [1:0] a, bit cur);
      case (a)
         2'd1: return 1'b0;
         2'd2: return 1'b1;
         2'd3: return !cur;
         default: return cur;
      endcase
   endfunction

   always_comb begin
      m_div  = (cfg_psc == 12'd0) ? 1 : int'(cfg_psc);
      m_tick = !cnt_clear && (m_pc >= m_div - 1);
      m_live = m_tick && (m_per != 0);
      m_rise = (cfg_mode != 2'd1) && ((cfg_mode != 2'd2) || m_dir);
      x_z    = m_live && (m_cnt == 0);
      x_p    = m_live && (m_cnt == m_per);
      x_cu   = m_live && (m_cnt == m_cmp) && m_rise;
      x_cd   = m_live && (m_cnt == m_cmp) && !m_rise;
      if (m_per == 0)           m_bnd = 1'b1;
      else if (cfg_mode == 2'd1) m_bnd = (m_cnt == 0);
      else if (cfg_mode == 2'd2) m_bnd = (m_cnt == 0) && !m_dir;
      else                       m_bnd = (m_cnt == m_per);
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_per <= 0; m_cmp <= 0; m_pc <= 0; m_dir <= 1'b1; m_lvl <= 1'b0;
      end else begin
         if (cnt_clear) begin
            m_pc  <= 0;
            m_per <= int'(cfg_period);
            m_cmp <= int'(cfg_compare);
            m_cnt <= (cfg_mode == 2'd1) ? int'(cfg_period) : 0;
            m_dir <= (cfg_mode != 2'd1);
         end else if (m_tick) begin
            m_pc <= 0;
            if (m_bnd) begin
               m_per <= int'(cfg_period);
               m_cmp <= int'(cfg_compare);
               m_dir <= (cfg_mode != 2'd1);
               if (cfg_period == 16'd0)                  m_cnt <= 0;
               else if (cfg_mode == 2'd1)                m_cnt <= int'(cfg_period);
               else if (cfg_mode == 2'd2 && m_per != 0)  m_cnt <= 1;
               else                                      m_cnt <= 0;
            end else if (cfg_mode == 2'd1) begin
               m_cnt <= m_cnt - 1;
            end else if (cfg_mode == 2'd2) begin
               if (m_dir && m_cnt == m_per) begin
                  m_cnt <= m_cnt - 1;
                  m_dir <= 1'b0;
               end else begin
                  m_cnt <= m_dir ? m_cnt + 1 : m_cnt - 1;
               end
            end else begin
               m_cnt <= m_cnt + 1;
            end
         end else begin
            m_pc <= m_pc + 1;
         end
         if (x_p)       m_lvl <= act_of(act_period, m_lvl);
         else if (x_cu) m_lvl <= act_of(act_cmp_up, m_lvl);
         else if (x_cd) m_lvl <= act_of(act_cmp_dn, m_lvl);
         else if (x_z)  m_lvl <= act_of(act_zero, m_lvl);
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(string tag);
      int exp_out;
      exp_out = int'((mask_en ? bit'(mask_level) : m_lvl) ^ bit'(cfg_invert));
      check(tag, "count", int'(cnt_value), m_cnt);
      check(tag, "events", int'({ev_zero, ev_cmp_up, ev_period, ev_cmp_dn}),
            int'({x_z, x_cu, x_p, x_cd}));
      check(tag, "output", int'(pwm_out), exp_out);
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         compare_all(tag);
      end
   endtask

   task automatic setup(int mode, int per, int cmp, int psc,
                        int az, int acu, int ap, int acd, string tag);
      cfg_mode    = 2'(mode);
      cfg_period  = 16'(per);
      cfg_compare = 16'(cmp);
      cfg_psc     = 12'(psc);
      act_zero    = 2'(az);
      act_cmp_up  = 2'(acu);
      act_period  = 2'(ap);
      act_cmp_dn  = 2'(acd);
      cnt_clear   = 1'b1;
      run(1, tag);
      cnt_clear   = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      run(3, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      run(4, "R1");

      // R2: divider pacing, including setting 0
      setup(0, 3, 1, 4, 2, 1, 0, 0, "R2");
      run(40, "R2");
      setup(0, 3, 1, 0, 2, 1, 0, 0, "R2");
      run(12, "R2");
      setup(2, 2, 1, 3, 2, 1, 0, 0, "R2");
      run(30, "R2");

      // R3: every mode over small top values
      for (int md = 0; md < 4; md++)
         for (int p = 1; p <= 5; p++) begin
            setup(md, p, 1, 1, 2, 1, 3, 1, "R3");
            run(3 * (2 * p + 2), "R3");
         end

      // R4: compare sweep from 0 to one past the top
      for (int md = 0; md < 3; md++)
         for (int c = 0; c <= 5; c++)
            for (int ps = 1; ps <= 2; ps++) begin
               setup(md, 4, c, ps, 3, 2, 0, 1, "R4");
               run(ps * 24, "R4");
            end

      // R5: every action code on every event
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++) begin
            setup(2, 3, 1, 1, a, b, 3 - a, 3 - b, "R5");
            run(20, "R5");
         end

      // R6: coincident events (compare at zero and at top)
      for (int md = 0; md < 3; md++)
         for (int a = 0; a < 4; a++) begin
            setup(md, 3, 0, 1, a, 3 - a, (a + 1) % 4, (a + 2) % 4, "R6");
            run(16, "R6");
            setup(md, 3, 3, 1, (a + 3) % 4, a, 3 - a, (a + 1) % 4, "R6");
            run(16, "R6");
         end

      // R7: shadow values change mid-cycle
      for (int md = 0; md < 3; md++) begin
         setup(md, 5, 2, 1, 2, 1, 3, 1, "R7");
         run(3, "R7");
         cfg_period  = 16'd2;
         cfg_compare = 16'd1;
         run(30, "R7");
         cfg_period  = 16'd6;
         cfg_compare = 16'd4;
         run(30, "R7");
      end

      // R8: top value 0 stops the counter, then restarts
      for (int md = 0; md < 3; md++) begin
         setup(md, 3, 1, 2, 3, 3, 3, 3, "R8");
         run(5, "R8");
         cfg_period = 16'd0;
         run(30, "R8");
         cfg_period = 16'd3;
         run(30, "R8");
      end

      // R9: mask override
      setup(0, 4, 2, 1, 2, 1, 0, 0, "R9");
      mask_en = 1'b1; mask_level = 1'b1;
      run(10, "R9");
      mask_level = 1'b0;
      run(10, "R9");
      mask_en = 1'b0;
      run(10, "R9");

      // R10: inversion with and without mask
      cfg_invert = 1'b1;
      run(12, "R10");
      mask_en = 1'b1; mask_level = 1'b1;
      run(6, "R10");
      mask_en = 1'b0; cfg_invert = 1'b0;
      run(6, "R10");

      // R11: clear at arbitrary points in every mode
      for (int md = 0; md < 3; md++)
         for (int k = 1; k <= 7; k += 3) begin
            setup(md, 5, 2, 2, 2, 1, 3, 1, "R11");
            run(k * 3, "R11");
            cfg_period = 16'd4;
            cnt_clear  = 1'b1;
            run(1, "R11");
            cnt_clear  = 1'b0;
            run(20, "R11");
         end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule